// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host-side register front end of a three-channel interval timer. A host reaches it through a 2-bit address, an 8-bit write bus, an 8-bit read bus and separate read and write strobes. Addresses 0, 1 and 2 are the data ports of the three channels. Address 3 is a write-only control port.

The block decodes control words. It steps each channel through the low-byte and high-byte order used to assemble a 16-bit reload value and to split a count into bytes for reading. For every channel it holds one count snapshot and one status snapshot. It also serves a read-back command that can take snapshots of several channels in one write.

On the channel side, the block hands each counter a one-cycle load pulse with the assembled value, plus the configured counting mode and decimal flag. In return it receives each counter's live count and output level. The counting itself is done by the channels.

Top module: `timer_regif`

## Requirements
- R1: After reset every channel is in low-then-high access mode with mode 0, decimal flag 0, no count or status snapshot pending and no load pulse. A live read of a channel returns its low byte first.
- R2: A write to address 3 whose bits 7:6 hold a channel number (0 to 2) and whose bits 5:4 are nonzero sets that channel's access mode from bits 5:4 (1 low only, 2 high only, 3 low then high), its counting mode from bits 3:1 and its decimal flag from bit 0. The counting mode and decimal flag appear on `chMode` and `chBcd` from the next cycle.
- R3: Such a configuring write restarts that channel's write and read byte order, so the next data write and the next live read both handle the low byte.
- R4: In low-then-high mode the first data write is only held and gives no load. The second one loads {second byte, first byte}, and the order then returns to expecting the low byte.
- R5: In low-only mode a data write loads {8'h00, byte}. In high-only mode it loads {byte, 8'h00}.
- R6: A control word with bits 5:4 equal to 0 snapshots the channel's live count. While a snapshot is not yet fully read, a further snapshot request is ignored. The snapshot is read as the low byte (low only), the high byte (high only) or low then high (low-then-high), using the access mode that applied when it was taken.
- R7: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 snapshots the count and bit 4 at 0 snapshots the status. A status snapshot that is still unread is kept.
- R8: The status byte holds the channel output level in bit 7, 0 in bit 6, the access mode in bits 5:4, the counting mode in bits 3:1 and the decimal flag in bit 0.
- R9: A data-port read returns a pending status snapshot first and clears it. Otherwise it returns pending count-snapshot bytes. Only when neither is pending does it return the live count.
- R10: A read of address 3 returns 0 and changes no state. `rdData` is 0 whenever `rdEn` is low.
- R11: Live reads in low-then-high mode alternate between the low and the high byte. In low-only or high-only mode every live read returns that same byte.
- R12: A data write that completes a value raises exactly that channel's `loadStrobe` bit for the one cycle after the write, with the value on that channel's 16-bit slice of `loadValue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 to 2 data ports, 3 control port |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| rdEn | input | 1 | Read strobe; read state advances at the clock edge |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte, valid in the cycle `rdEn` is high |
| chCount | input | 48 | Live counts, channel n at bits 16n+15:16n |
| chOut | input | 3 | Output level of each channel |
| loadStrobe | output | 3 | One-cycle reload pulse per channel |
| loadValue | output | 48 | Reload value, channel n at bits 16n+15:16n |
| chMode | output | 9 | Counting mode, channel n at bits 3n+2:3n |
| chBcd | output | 3 | Decimal counting flag per channel |

## Verification
Directed sequences test the byte order on its own: a held first byte that gives no load, a reconfigure in the middle of a pair, and reads that alternate between halves. These show that write order and read order are kept apart and restarted. Snapshot patterns change the live count after a latch and issue a second latch or read-back before the first one is read. This shows snapshot holding apart from live pass-through, and it shows the rule that a pending snapshot is not overwritten. Mixed read-back commands that ask for both status and count check that the status comes out first. A seeded random mix of control words, data writes, reads and moving live counts is compared against a byte-level model. This exposes wrong interactions between snapshots, access modes and sequencing state.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LOW   = 2'd1,
    ACC_HIGH  = 2'd2,
    ACC_WORD  = 2'd3
  } accMode_e;

  typedef struct packed {
    logic cfgWr;
    logic cntLatch;
    logic statLatch;
    logic dataWr;
    logic dataRd;
  } chStrobe_t;

  localparam logic [1:0] CTRL_ADDR = 2'd3;

endpackage

// File: rtl/timer_regif_ctrl.sv
module timer_regif_ctrl
  import timer_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]              addr,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [BYTE_W-1:0]       wrData,
  output chStrobe_t [NUM_CH-1:0]  strobe
);

  logic isCtrlWr;
  logic isReadBack;
  logic isLatchCmd;

  assign isCtrlWr   = wrEn && (addr == CTRL_ADDR);
  assign isReadBack = (wrData[7:6] == 2'd3);
  assign isLatchCmd = (wrData[5:4] == ACC_LATCH);

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (isCtrlWr) begin
        if (isReadBack) begin
          if (wrData[i+1]) begin
            strobe[i].cntLatch  = !wrData[5];
            strobe[i].statLatch = !wrData[4];
          end
        end else if (wrData[7:6] == 2'(i)) begin
          strobe[i].cntLatch = isLatchCmd;
          strobe[i].cfgWr    = !isLatchCmd;
        end
      end
      strobe[i].dataWr = wrEn && (addr == 2'(i));
      strobe[i].dataRd = rdEn && (addr == 2'(i));
    end
  end

endmodule

// File: rtl/timer_regif_chan.sv
module timer_regif_chan
  import timer_regif_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  liveCnt,
  input  logic              outLvl,
  output logic [BYTE_W-1:0] rdByte,
  output logic              loadStrobe,
  output logic [CNT_W-1:0]  loadValue,
  output logic [2:0]        mode,
  output logic              bcd
);

  accMode_e          accMode;
  accMode_e          latchPend;
  logic              wrHigh;
  logic              rdHigh;
  logic [BYTE_W-1:0] lowHold;
  logic [CNT_W-1:0]  latchedCnt;
  logic              statLatched;
  logic [BYTE_W-1:0] statByte;

  logic [BYTE_W-1:0] liveLo, liveHi;
  assign liveLo = liveCnt[BYTE_W-1:0];
  assign liveHi = liveCnt[CNT_W-1:BYTE_W];

  always_comb begin
    if (statLatched) begin
      rdByte = statByte;
    end else if (latchPend != ACC_LATCH) begin
      rdByte = (latchPend == ACC_HIGH) ? latchedCnt[CNT_W-1:BYTE_W]
                                       : latchedCnt[BYTE_W-1:0];
    end else begin
      case (accMode)
        ACC_HIGH: rdByte = liveHi;
        ACC_WORD: rdByte = rdHigh ? liveHi : liveLo;
        default:  rdByte = liveLo;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accMode     <= ACC_WORD;
      mode        <= '0;
      bcd         <= 1'b0;
      wrHigh      <= 1'b0;
      rdHigh      <= 1'b0;
      lowHold     <= '0;
      latchPend   <= ACC_LATCH;
      latchedCnt  <= '0;
      statLatched <= 1'b0;
      statByte    <= '0;
      loadStrobe  <= 1'b0;
      loadValue   <= '0;
    end else begin
      loadStrobe <= 1'b0;

      if (strobe.cfgWr) begin
        accMode <= accMode_e'(wrData[5:4]);
        mode    <= wrData[3:1];
        bcd     <= wrData[0];
        wrHigh  <= 1'b0;
        rdHigh  <= 1'b0;
      end

      if (strobe.dataWr) begin
        case (accMode)
          ACC_LOW: begin
            loadStrobe <= 1'b1;
            loadValue  <= {{BYTE_W{1'b0}}, wrData};
          end
          ACC_HIGH: begin
            loadStrobe <= 1'b1;
            loadValue  <= {wrData, {BYTE_W{1'b0}}};
          end
          default: begin
            if (!wrHigh) begin
              lowHold <= wrData;
              wrHigh  <= 1'b1;
            end else begin
              loadStrobe <= 1'b1;
              loadValue  <= {wrData, lowHold};
              wrHigh     <= 1'b0;
            end
          end
        endcase
      end

      if (strobe.dataRd) begin
        if (statLatched) begin
          statLatched <= 1'b0;
        end else if (latchPend != ACC_LATCH) begin
          latchPend <= (latchPend == ACC_WORD) ? ACC_HIGH : ACC_LATCH;
        end else if (accMode == ACC_WORD) begin
          rdHigh <= !rdHigh;
        end
      end

      if (strobe.cntLatch && (latchPend == ACC_LATCH)) begin
        latchedCnt <= liveCnt;
        latchPend  <= accMode;
      end

      if (strobe.statLatch && !statLatched) begin
        statByte    <= {outLvl, 1'b0, accMode, mode, bcd};
        statLatched <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/timer_regif_datapath.sv
module timer_regif_datapath
  import timer_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chStrobe_t [NUM_CH-1:0]  strobe,
  input  logic [1:0]              addr,
  input  logic                    rdEn,
  input  logic [BYTE_W-1:0]       wrData,
  input  logic [NUM_CH*CNT_W-1:0] chCount,
  input  logic [NUM_CH-1:0]       chOut,
  output logic [BYTE_W-1:0]       rdData,
  output logic [NUM_CH-1:0]       loadStrobe,
  output logic [NUM_CH*CNT_W-1:0] loadValue,
  output logic [NUM_CH*3-1:0]     chMode,
  output logic [NUM_CH-1:0]       chBcd
);

  logic [BYTE_W-1:0] chByte [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    timer_regif_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk        (clk),
      .rstN       (rstN),
      .strobe     (strobe[g]),
      .wrData     (wrData),
      .liveCnt    (chCount[g*CNT_W +: CNT_W]),
      .outLvl     (chOut[g]),
      .rdByte     (chByte[g]),
      .loadStrobe (loadStrobe[g]),
      .loadValue  (loadValue[g*CNT_W +: CNT_W]),
      .mode       (chMode[g*3 +: 3]),
      .bcd        (chBcd[g])
    );
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rdEn && (addr == 2'(i))) rdData = chByte[i];
    end
  end

endmodule

// File: rtl/timer_regif.sv
module timer_regif
  import timer_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              addr,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [BYTE_W-1:0]       wrData,
  output logic [BYTE_W-1:0]       rdData,
  input  logic [NUM_CH*CNT_W-1:0] chCount,
  input  logic [NUM_CH-1:0]       chOut,
  output logic [NUM_CH-1:0]       loadStrobe,
  output logic [NUM_CH*CNT_W-1:0] loadValue,
  output logic [NUM_CH*3-1:0]     chMode,
  output logic [NUM_CH-1:0]       chBcd
);

  chStrobe_t [NUM_CH-1:0] strobe;

  timer_regif_ctrl #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrData (wrData),
    .strobe (strobe)
  );

  timer_regif_datapath #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr       (addr),
    .rdEn       (rdEn),
    .wrData     (wrData),
    .chCount    (chCount),
    .chOut      (chOut),
    .rdData     (rdData),
    .loadStrobe (loadStrobe),
    .loadValue  (loadValue),
    .chMode     (chMode),
    .chBcd      (chBcd)
  );

endmodule

// File: rtl/timer_regif_chk.sv
module timer_regif_chk #(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [1:0]              addr,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [BYTE_W-1:0]       wrData,
  input logic [BYTE_W-1:0]       rdData,
  input logic [NUM_CH*CNT_W-1:0] chCount,
  input logic [NUM_CH-1:0]       chOut,
  input logic [NUM_CH-1:0]       loadStrobe,
  input logic [NUM_CH*CNT_W-1:0] loadValue,
  input logic [NUM_CH*3-1:0]     chMode,
  input logic [NUM_CH-1:0]       chBcd
);

  a_r12_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStrobe));

  a_r10_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd3) |-> (rdData == '0));

  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    a_r12_load_after_write: assert property (@(posedge clk) disable iff (!rstN)
      loadStrobe[g] |-> $past(wrEn && addr == 2'(g)));

    a_r2_mode_follows_cfg: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == 2'd3 && wrData[7:6] == 2'(g) && wrData[5:4] != 2'd0)
        |=> (chMode[g*3 +: 3] == $past(wrData[3:1])) && (chBcd[g] == $past(wrData[0])));
  end

endmodule

bind timer_regif timer_regif_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/timer_regif_bench.sv
`timescale 1ns/1ps
module timer_regif_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [47:0] chCount;
  logic [2:0]  chOut = '0;
  logic [2:0]  loadStrobe;
  logic [47:0] loadValue;
  logic [8:0]  chMode;
  logic [2:0]  chBcd;

  logic [15:0] live [3];
  assign chCount = {live[2], live[1], live[0]};

  always #5 clk = !clk;

  timer_regif u_timer_regif (.*);

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // byte-level model state
  logic [1:0]  mAcc [3];
  logic [2:0]  mMode [3];
  logic        mBcd [3];
  logic        mWrHi [3];
  logic        mRdHi [3];
  logic [7:0]  mHold [3];
  logic [1:0]  mPend [3];
  logic [15:0] mLat [3];
  logic        mStatL [3];
  logic [7:0]  mStat [3];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mReset();
    for (int c = 0; c < 3; c++) begin
      mAcc[c] = 2'd3; mMode[c] = 3'd0; mBcd[c] = 1'b0;
      mWrHi[c] = 1'b0; mRdHi[c] = 1'b0; mHold[c] = 8'd0;
      mPend[c] = 2'd0; mLat[c] = 16'd0; mStatL[c] = 1'b0; mStat[c] = 8'd0;
    end
  endtask

  task automatic mLatchCnt(int c);
    if (mPend[c] == 2'd0) begin
      mLat[c] = live[c];
      mPend[c] = mAcc[c];
    end
  endtask

  task automatic mCtrl(logic [7:0] d);
    int sel = int'(d[7:6]);
    if (sel == 3) begin
      for (int c = 0; c < 3; c++) begin
        if (d[c+1]) begin
          if (!d[5]) mLatchCnt(c);
          if (!d[4] && !mStatL[c]) begin
            mStat[c] = {chOut[c], 1'b0, mAcc[c], mMode[c], mBcd[c]};
            mStatL[c] = 1'b1;
          end
        end
      end
    end else if (d[5:4] == 2'd0) begin
      mLatchCnt(sel);
    end else begin
      mAcc[sel] = d[5:4]; mMode[sel] = d[3:1]; mBcd[sel] = d[0];
      mWrHi[sel] = 1'b0; mRdHi[sel] = 1'b0;
    end
  endtask

  task automatic mData(int c, logic [7:0] d, output logic ld, output logic [15:0] v);
    ld = 1'b1; v = 16'd0;
    case (mAcc[c])
      2'd1: v = {8'h00, d};
      2'd2: v = {d, 8'h00};
      default: begin
        if (!mWrHi[c]) begin
          mHold[c] = d; mWrHi[c] = 1'b1; ld = 1'b0;
        end else begin
          v = {d, mHold[c]}; mWrHi[c] = 1'b0;
        end
      end
    endcase
  endtask

  task automatic mRead(int a, output logic [7:0] v);
    v = 8'h00;
    if (a < 3) begin
      if (mStatL[a]) begin
        v = mStat[a]; mStatL[a] = 1'b0;
      end else if (mPend[a] != 2'd0) begin
        v = (mPend[a] == 2'd2) ? mLat[a][15:8] : mLat[a][7:0];
        mPend[a] = (mPend[a] == 2'd3) ? 2'd2 : 2'd0;
      end else begin
        case (mAcc[a])
          2'd2: v = live[a][15:8];
          2'd3: begin
            v = mRdHi[a] ? live[a][15:8] : live[a][7:0];
            mRdHi[a] = !mRdHi[a];
          end
          default: v = live[a][7:0];
        endcase
      end
    end
  endtask

  task automatic doWrite(logic [1:0] a, logic [7:0] d, string tag);
    logic ld;
    logic [15:0] v;
    ld = 1'b0; v = 16'd0;
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    if (a == 2'd3) mCtrl(d);
    else mData(int'(a), d, ld, v);
    @(negedge clk);
    wrEn = 1'b0;
    check({tag, " load pulse"}, 32'(loadStrobe), (a != 2'd3 && ld) ? 32'(3'b001 << a) : 32'd0);
    if (a != 2'd3 && ld) check({tag, " load value"}, 32'(loadValue[a*16 +: 16]), 32'(v));
    if (a == 2'd3 && d[7:6] != 2'd3 && d[5:4] != 2'd0)
      check({tag, " mode/bcd"}, 32'({chMode[d[7:6]*3 +: 3], chBcd[d[7:6]]}), 32'(d[3:0]));
  endtask

  task automatic doRead(logic [1:0] a, string tag, output logic [7:0] got);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 got = rdData;
    mRead(int'(a), e);
    check(tag, 32'(got), 32'(e));
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdExp(logic [1:0] a, logic [7:0] exp, string tag);
    logic [7:0] got;
    doRead(a, tag, got);
    check({tag, " directed"}, 32'(got), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    live[0] = 16'hABCD; live[1] = 16'h0000; live[2] = 16'h0000;
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 no load after reset", 32'(loadStrobe), 32'd0);
    check("R1 mode/bcd after reset", 32'({chMode, chBcd}), 32'd0);
    rdExp(2'd0, 8'hCD, "R1 first live read low");
    rdExp(2'd0, 8'hAB, "R11 second live read high");

    // R4 word load on channel 1
    doWrite(2'd3, 8'h70, "R2 cfg ch1 word");
    doWrite(2'd1, 8'h34, "R4 first byte held");
    doWrite(2'd1, 8'h12, "R4 second byte loads");
    check("R4 value 1234", 32'(loadValue[31:16]), 32'h1234);

    // R5 low only / high only
    doWrite(2'd3, 8'h94, "R2 cfg ch2 low only");
    doWrite(2'd2, 8'h5A, "R5 low only load");
    check("R5 low only value", 32'(loadValue[47:32]), 32'h005A);
    doWrite(2'd3, 8'h27, "R2 cfg ch0 high only bcd");
    doWrite(2'd0, 8'h77, "R5 high only load");
    check("R5 high only value", 32'(loadValue[15:0]), 32'h7700);

    // R6 latch, second latch ignored
    live[1] = 16'h4321;
    doWrite(2'd3, 8'h40, "R6 latch ch1");
    live[1] = 16'h9999;
    doWrite(2'd3, 8'h40, "R6 second latch ignored");
    rdExp(2'd1, 8'h21, "R6 latched low");
    rdExp(2'd1, 8'h43, "R6 latched high");
    rdExp(2'd1, 8'h99, "R9 live after latch drained");

    // R3 cfg restarts sequencing
    doWrite(2'd1, 8'h11, "R3 held byte");
    doWrite(2'd3, 8'h70, "R3 reconfigure ch1");
    doWrite(2'd1, 8'h22, "R3 new low byte");
    doWrite(2'd1, 8'h33, "R3 new high byte");
    check("R3 value 3322", 32'(loadValue[31:16]), 32'h3322);
    live[1] = 16'h5678;
    rdExp(2'd1, 8'h78, "R3 read order restarted");

    // R7/R8 status read-back, not overwritten
    chOut = 3'b101;
    doWrite(2'd3, 8'hE2, "R7 status readback ch0");
    chOut = 3'b000;
    doWrite(2'd3, 8'hE2, "R7 status kept");
    rdExp(2'd0, 8'hA7, "R8 status byte");
    rdExp(2'd0, 8'hAB, "R9 live after status");

    // R7 multi-channel count read-back
    live[1] = 16'hBEEF; live[2] = 16'h0102;
    doWrite(2'd3, 8'hDC, "R7 count readback ch1 ch2");
    live[1] = 16'h0000; live[2] = 16'h0000;
    rdExp(2'd2, 8'h02, "R7 ch2 snapshot");
    rdExp(2'd1, 8'hEF, "R7 ch1 snapshot low");
    rdExp(2'd1, 8'hBE, "R7 ch1 snapshot high");

    // R9 status before count
    live[2] = 16'h00C3; chOut = 3'b100;
    doWrite(2'd3, 8'hC8, "R9 both snapshots ch2");
    live[2] = 16'h0011;
    rdExp(2'd2, 8'h94, "R9 status first");
    rdExp(2'd2, 8'hC3, "R9 count second");
    rdExp(2'd2, 8'h11, "R11 low only live");
    rdExp(2'd2, 8'h11, "R11 low only repeat");

    // R10 control port read
    rdExp(2'd3, 8'h00, "R10 control read zero");
    rdExp(2'd0, 8'hAB, "R10 no side effect");

    // random mix
    void'($urandom(32'd2718));
    for (int it = 0; it < 1500; it++) begin
      int op = int'($urandom_range(0, 9));
      int c = int'($urandom_range(0, 2));
      logic [7:0] d = 8'($urandom);
      live[c] = 16'($urandom);
      chOut = 3'($urandom);
      if (op == 0) begin
        doWrite(2'd3, {2'(c), d[5:0]}, "R2 random control");
      end else if (op == 1) begin
        doWrite(2'd3, {2'b11, d[5:1], 1'b0}, "R7 random readback");
      end else if (op <= 4) begin
        doWrite(2'(c), d, "R12 random data write");
      end else if (op == 9) begin
        doRead(2'd3, "R10 random control read", junk);
      end else begin
        doRead(2'(c), "R9 random read", junk);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule